// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is an I2C target that looks to a bus controller like a small byte-wide serial EEPROM. It oversamples the open-drain SCL and SDA lines on the system clock. It recognises start and stop conditions and answers to a four-bit device code. Behind the bus logic sit a 128-byte register-array memory and an 8-byte page latch. Written bytes are gathered in the page latch and reach the array only when a stop condition arrives. After each committed write, a fixed busy period models the write cycle. During that period the target refuses its control byte.

Reads use one internal address pointer. A read with no address phase returns the byte at the pointer. A random read loads the pointer with a word-address write, then uses a repeated start to turn around to a read. In a sequential read, the controller acknowledges each byte and the pointer advances across the whole array. A write-protect input suppresses every commit, and leaves reads unaffected.

There is no valid/ready stream at the edge. Data moves only as fast as the controller clocks SCL, and the only back-pressure the target applies is to NACK its control byte while it is busy. Every pin is plain. `sda_oe` high means the target pulls SDA low. The surrounding logic must combine it with the pull-up, so that the line seen on `sda_in` is the wired-AND of all drivers.

Top module: `serial_eeprom_target`

## Requirements
- R1: A falling SDA while SCL is high is a start condition. A rising SDA while SCL is high is a stop condition. SDA changes while SCL is low are data. The target changes its own SDA drive only while SCL is low.
- R2: After a start, the first byte is the control byte, sent MSB first. If its upper four bits are 1010, the target ACKs by pulling SDA low for the ninth SCL pulse, and bit 0 selects read (1) or write (0). Bits 3..1 are don't-care. Any other code gets no ACK, and the target then ignores the bus until the next start.
- R3: In a write, the byte after the control byte is the word address. It is ACKed, and its low 7 bits load the address pointer. Bit 7 is ignored.
- R4: Each data byte after the word address is ACKed and latched at the pointer's low 3 bits, which then advance and wrap within the 8-byte page. The upper 4 bits stay fixed. The stop condition writes all latched bytes into the array together.
- R5: If wp is high at the stop, nothing is written and no busy period starts. Reads return array contents whatever the level of wp.
- R6: A committed write starts a busy period of WR_CYCLES clk cycles. During that period the control byte is NACKed.
- R7: A read control byte that is not preceded by an address phase returns the byte at the pointer. The pointer then advances by one.
- R8: A word-address write followed by a repeated start and a read control byte returns the byte at that address.
- R9: While the controller ACKs read bytes, the target sends consecutive bytes, and the pointer wraps from 0x7F to 0x00.
- R10: When the controller NACKs a read byte, the target releases SDA and drives nothing more until the next start.
- R11: After reset, SDA is released, the pointer is 0x00 and every array byte is 0x00.
- R12: Data bytes that a repeated start cuts off, rather than a stop, are discarded and start no busy period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level (wired-AND of all drivers) |
| wp | input | 1 | Write protect; high blocks commits |
| sda_oe | output | 1 | High pulls SDA low |

## Verification
Both bus lines pass through a two-stage synchronizer and an edge register. As a result, each SCL edge takes effect three clk cycles after the controller makes it. An ACK or read bit is therefore on the line well before the middle of the following SCL-high phase. The bench samples SDA only at that midpoint, with SCL half-phases of twelve clk cycles. The busy window is timed from stop detection. The bench probes it with a control byte that finishes well inside WR_CYCLES. After each commit it waits WR_CYCLES plus margin before the next access. Read bytes are checked by a scoreboard against a memory model that the bench updates from the requirements.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int DATA_W = 8;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA,
    ST_RACK
  } eep_state_t;
endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_in};
      sda_sh <= {sda_sh[STAGES-2:0], sda_in};
      scl_q  <= scl_sh[STAGES-1];
      sda_q  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int PAGE_W = 3,
  parameter int DATA_W = 8,
  localparam int PAGE_BYTES = 1 << PAGE_W
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  clr,
  input  logic                                  wr,
  input  logic [PAGE_W-1:0]                     idx,
  input  logic [DATA_W-1:0]                     data,
  output logic [PAGE_BYTES-1:0][DATA_W-1:0]     bytes,
  output logic [PAGE_BYTES-1:0]                 valid
);
  for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bytes[s] <= '0;
        valid[s] <= 1'b0;
      end else if (clr) begin
        valid[s] <= 1'b0;
      end else if (wr && idx == PAGE_W'(s)) begin
        bytes[s] <= data;
        valid[s] <= 1'b1;
      end
    end
  end

  // A latched byte must be marked for the next commit
  assert_wr_marks_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !clr) |=> valid[$past(idx)]);
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int ADDR_W = 7,
  parameter int PAGE_W = 3,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int PAGE_BYTES = 1 << PAGE_W,
  localparam int PG_W = ADDR_W - PAGE_W
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              commit,
  input  logic [PG_W-1:0]                   page_sel,
  input  logic [PAGE_BYTES-1:0][DATA_W-1:0] bytes,
  input  logic [PAGE_BYTES-1:0]             valid,
  input  logic [ADDR_W-1:0]                 rd_addr,
  output logic [DATA_W-1:0]                 rd_data
);
  logic [DEPTH-1:0][DATA_W-1:0] words;

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    localparam logic [PG_W-1:0] MY_PAGE = PG_W'(w / PAGE_BYTES);
    localparam int MY_SLOT = w % PAGE_BYTES;
    logic [DATA_W-1:0] word;
    logic              hit;

    assign hit = commit && page_sel == MY_PAGE && valid[MY_SLOT];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word <= '0;
      else if (hit) word <= bytes[MY_SLOT];
    end
    assign words[w] = word;

    assert_commit_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> word == $past(bytes[MY_SLOT]));
  end

  assign rd_data = words[rd_addr];
endmodule

// File: rtl/eep_busy_timer.sv
module eep_busy_timer #(
  parameter int CYCLES = 5000,
  localparam int CNT_W = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (load)      cnt <= CNT_W'(CYCLES);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy = cnt != '0;

  assert_busy_counts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load) |=> cnt == $past(cnt) - 1'b1);
  assert_load_sets_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy);
endmodule

// File: rtl/serial_eeprom_target.sv
module serial_eeprom_target
  import eep_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int PAGE_W      = 3,
  parameter int WR_CYCLES   = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic wp,
  output logic sda_oe
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int PG_W       = ADDR_W - PAGE_W;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  eep_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  eep_state_t        state;
  logic              in_ack, drive, rw, got_ack;
  logic [3:0]        bit_cnt;
  logic [DATA_W-1:0] rx_sh, tx_sh;
  logic [ADDR_W-1:0] ptr;

  logic                              pb_wr, pb_clr, commit, busy;
  logic [PAGE_BYTES-1:0][DATA_W-1:0] pb_bytes;
  logic [PAGE_BYTES-1:0]             pb_valid;
  logic [DATA_W-1:0]                 rd_data;
  logic                              byte_done, ctrl_ok;

  assign byte_done = scl_fall && !in_ack && bit_cnt == 4'd8;
  assign ctrl_ok   = rx_sh[7:4] == DEV_CODE && !busy;
  assign pb_wr     = state == ST_WDATA && byte_done && !start_det && !stop_det;
  assign pb_clr    = start_det || stop_det;
  assign commit    = stop_det && (|pb_valid) && !wp;

  eep_page_buf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_page (
    .clk(clk), .rst_n(rst_n), .clr(pb_clr), .wr(pb_wr),
    .idx(ptr[PAGE_W-1:0]), .data(rx_sh), .bytes(pb_bytes), .valid(pb_valid)
  );

  eep_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n), .commit(commit),
    .page_sel(ptr[ADDR_W-1:PAGE_W]), .bytes(pb_bytes), .valid(pb_valid),
    .rd_addr(ptr), .rd_data(rd_data)
  );

  eep_busy_timer #(.CYCLES(WR_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n), .load(commit), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      in_ack  <= 1'b0;
      drive   <= 1'b0;
      rw      <= 1'b0;
      got_ack <= 1'b0;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      ptr     <= '0;
    end else if (start_det) begin
      state   <= ST_CTRL;
      in_ack  <= 1'b0;
      drive   <= 1'b0;
      bit_cnt <= '0;
    end else if (stop_det) begin
      state   <= ST_IDLE;
      in_ack  <= 1'b0;
      drive   <= 1'b0;
      bit_cnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_CTRL, ST_ADDR, ST_WDATA: begin
          if (in_ack) begin
            if (scl_fall) begin
              in_ack  <= 1'b0;
              drive   <= 1'b0;
              bit_cnt <= '0;
              if (state == ST_CTRL && rw) begin
                tx_sh <= rd_data;
                ptr   <= ptr + 1'b1;
                drive <= ~rd_data[DATA_W-1];
                state <= ST_RDATA;
              end else if (state == ST_CTRL) begin
                state <= ST_ADDR;
              end else begin
                state <= ST_WDATA;
              end
            end
          end else if (scl_rise && bit_cnt != 4'd8) begin
            rx_sh   <= {rx_sh[DATA_W-2:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (byte_done) begin
            if (state == ST_CTRL) begin
              if (ctrl_ok) begin
                in_ack <= 1'b1;
                drive  <= 1'b1;
                rw     <= rx_sh[0];
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              in_ack <= 1'b1;
              drive  <= 1'b1;
              if (state == ST_ADDR) ptr <= rx_sh[ADDR_W-1:0];
              else ptr <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
            end
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (bit_cnt == 4'd7) begin
              drive   <= 1'b0;
              bit_cnt <= '0;
              state   <= ST_RACK;
            end else begin
              tx_sh   <= {tx_sh[DATA_W-2:0], 1'b0};
              drive   <= ~tx_sh[DATA_W-2];
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            got_ack <= ~sda_s;
            if (sda_s) state <= ST_IDLE;
          end else if (scl_fall && got_ack) begin
            tx_sh   <= rd_data;
            ptr     <= ptr + 1'b1;
            drive   <= ~rd_data[DATA_W-1];
            bit_cnt <= '0;
            state   <= ST_RDATA;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sda_oe = drive;

  // The target only starts pulling SDA while SCL is low
  assert_oe_rise_scl_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  // Entering the control-byte ACK is impossible while a write cycle runs
  assert_ctrl_ack_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(in_ack) && state == ST_CTRL) |-> !busy);
  // A busy period only follows an unprotected commit
  assert_wp_no_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wp));
  // An idle target never holds the line
  assert_idle_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_IDLE |-> !sda_oe);
  // Each further sequential byte moves the pointer by one
  assert_seq_ptr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RDATA && $past(state) == ST_RACK) |-> ptr == ADDR_W'($past(ptr) + 1'b1));
endmodule

// File: tb/test_serial_eeprom_target.sv
module test_serial_eeprom_target;
  localparam int WR = 400;
  localparam int H  = 12;

  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1, wp = 1'b0;
  logic sda_oe;
  wire  sda_bus = m_sda & ~sda_oe;

  always #10 clk = ~clk;

  serial_eeprom_target #(.WR_CYCLES(WR)) i_serial_eeprom_target (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
    .wp(wp), .sda_oe(sda_oe)
  );

  int n_tests = 0, n_fail = 0;
  logic [7:0] model [128];
  logic [6:0] mptr = '0;
  logic [7:0] exp_q[$], got_q[$];
  string      tag_q[$];

  task automatic check(input bit ok, input string tag, input int got, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, expv);
    end
  endtask

  initial forever begin
    @(negedge clk);
    while (got_q.size() > 0) begin
      logic [7:0] g, e;
      string t;
      g = got_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
      check(g == e, t, g, e);
    end
  end

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic bit_out(input logic b);
    tick(H/2); m_sda = b; tick(H/2); m_scl = 1'b1; tick(H); m_scl = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    tick(H/2); m_sda = 1'b1; tick(H/2); m_scl = 1'b1; tick(H/2); b = sda_bus; tick(H/2); m_scl = 1'b0;
  endtask

  task automatic bus_start;
    tick(H/2); m_sda = 1'b1; tick(H/2); m_scl = 1'b1; tick(H/2); m_sda = 1'b0; tick(H/2); m_scl = 1'b0;
  endtask

  task automatic bus_stop;
    tick(H/2); m_sda = 1'b0; tick(H/2); m_scl = 1'b1; tick(H/2); m_sda = 1'b1; tick(H);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(a);
    acked = ~a;
  endtask

  task automatic recv_byte(input logic give_ack, input string tag);
    logic [7:0] d;
    logic b;
    exp_q.push_back(model[mptr]); tag_q.push_back(tag);
    mptr = mptr + 1'b1;
    for (int i = 7; i >= 0; i--) begin bit_in(b); d[i] = b; end
    got_q.push_back(d);
    bit_out(~give_ack);
  endtask

  task automatic write_page(input logic [7:0] addr, input int n, input logic [7:0] d [8]);
    logic ak;
    logic [7:0] pend [8];
    logic [7:0] pmask;
    pmask = '0;
    bus_start;
    send_byte(8'hA0, ak); check(ak, "R2 write control ACK", ak, 1);
    send_byte(addr, ak);  check(ak, "R3 word address ACK", ak, 1);
    mptr = addr[6:0];
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], ak); check(ak, "R4 data byte ACK", ak, 1);
      pend[mptr[2:0]] = d[i]; pmask[mptr[2:0]] = 1'b1;
      mptr = {mptr[6:3], mptr[2:0] + 3'd1};
    end
    bus_stop;
    if (!wp)
      for (int s = 0; s < 8; s++) if (pmask[s]) model[{mptr[6:3], 3'(s)}] = pend[s];
  endtask

  task automatic random_read(input logic [7:0] addr, input int n, input string tag);
    logic ak;
    bus_start;
    send_byte(8'hA0, ak); check(ak, {tag, " dummy-write control ACK R8"}, ak, 1);
    send_byte(addr, ak);  check(ak, {tag, " dummy-write address ACK R8"}, ak, 1);
    mptr = addr[6:0];
    bus_start;
    send_byte(8'hA1, ak); check(ak, {tag, " read control ACK R8"}, ak, 1);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, tag);
    bus_stop;
  endtask

  initial begin
    logic ak;
    logic [7:0] d [8];
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    tick(5); rst_n = 1'b1; tick(5);
    check(sda_oe == 1'b0, "R11 SDA released after reset", sda_oe, 0);

    // R11 R7: current-address read from reset pointer 0
    bus_start;
    send_byte(8'hA1, ak); check(ak, "R1 R2 start then read control ACK", ak, 1);
    recv_byte(1'b1, "R11 R7 current read byte 0");
    recv_byte(1'b0, "R7 current read byte 1");
    tick(H/2);
    check(sda_oe == 1'b0, "R10 released after master NACK", sda_oe, 0);
    bus_stop;
    check(sda_oe == 1'b0, "R10 released through stop", sda_oe, 0);

    // R3 R4 R6: byte write with address bit 7 set, then busy probe
    d[0] = 8'h3C;
    write_page(8'h85, 1, d);
    bus_start;
    send_byte(8'hA0, ak); check(!ak, "R6 control NACK during write cycle", ak, 0);
    bus_stop;
    tick(WR + 50);
    random_read(8'h05, 2, "R3 R8 random read 0x05");

    // R4: page write wrapping inside page 0x18..0x1F
    d = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h00, 8'h00, 8'h00};
    write_page(8'h1E, 5, d);
    tick(WR + 50);
    random_read(8'h18, 8, "R4 R9 page wrap read");

    // R2: wrong device code and don't-care bits
    bus_start;
    send_byte(8'hB0, ak); check(!ak, "R2 wrong device code NACK", ak, 0);
    tick(H);
    check(sda_oe == 1'b0, "R2 ignored after bad code", sda_oe, 0);
    bus_start;
    send_byte(8'hAE, ak); check(ak, "R2 don't-care bits ACK", ak, 1);
    bus_stop;

    // R5: protected write leaves array and starts no busy period
    wp = 1'b1;
    d[0] = 8'h77;
    write_page(8'h40, 1, d);
    bus_start;
    send_byte(8'hA0, ak); check(ak, "R5 no busy after blocked write", ak, 1);
    bus_stop;
    random_read(8'h40, 1, "R5 protected byte unchanged");
    random_read(8'h1A, 1, "R5 read with wp high");
    wp = 1'b0;

    // R9: sequential read across end of array
    d[0] = 8'hA1; d[1] = 8'hA2;
    write_page(8'h7E, 2, d);
    tick(WR + 50);
    random_read(8'h7E, 4, "R9 wrap 0x7F to 0x00");

    // R12: data cut off by repeated start is discarded
    bus_start;
    send_byte(8'hA0, ak); check(ak, "R12 control ACK", ak, 1);
    send_byte(8'h30, ak); check(ak, "R12 address ACK", ak, 1);
    send_byte(8'h55, ak); check(ak, "R12 data ACK", ak, 1);
    mptr = 7'h31;
    bus_start;
    send_byte(8'hA1, ak); check(ak, "R12 no busy after aborted write", ak, 1);
    recv_byte(1'b0, "R12 R7 current read after abort");
    bus_stop;
    random_read(8'h30, 1, "R12 aborted byte not written");

    tick(20);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule